// File: doc/BRIEF.md
# Byte-Wide EPROM Bank Read Controller

This controller sits on the host side of a bank of byte-wide read-only memories that share one data bus. It takes one read request at a time over a valid/ready handshake. The upper request address bits pick a device, and the lower bits go out on the shared address bus. Each device has its own active-low chip enable, driven from the address decode, so every device that is not being read stays in low-power standby with its outputs off. One active-low output enable is common to all devices and acts as the read strobe.

All device timing is counted in clock cycles. Address and chip enable change on the same edge. The output enable follows after `max(T_ACC, T_CE) - T_OE` cycles, so all three access limits expire on one edge, `LAT = max(T_ACC, T_CE, T_OE)` cycles after the chip enable falls. The byte is captured on that edge. On the same edge both enables are released and the captured byte is returned with a one-cycle strobe. The address is held until after the capture, because the memories give no data hold after an address change.

If the next read targets a different device, the controller waits until `T_DF` cycles have passed since the release before it enables that device. This leaves the previous driver time to float. A read of the same device starts at once.

Top module: `eprom_bank_rd_ctrl`

## Requirements
- R1: While `rst_ni` is low, `req_ready_o` is 1, every bit of `mem_ce_no` is 1, `mem_oe_no` is 1 and `rsp_valid_o` is 0.
- R2: Request address bits `[DEV_AW+SEL_W-1:DEV_AW]` select device index d. During its access only `mem_ce_no[d]` is 0, and at no time is more than one chip enable low.
- R3: `mem_addr_o` carries request bits `[DEV_AW-1:0]` and does not change while any chip enable is low.
- R4: `mem_oe_no` falls exactly `max(T_ACC,T_CE) - T_OE` cycles after the chip enable falls, and it is low only while exactly one chip enable is low.
- R5: The byte on `mem_data_i` is captured `LAT` cycles after the chip enable falls. It appears on `rsp_data_o` while `rsp_valid_o` is high for exactly one cycle.
- R6: On the capture edge both the chip enable and the output enable return high, and the controller is ready again in that same response cycle.
- R7: When a request targets a device other than the one last read, that device's chip enable does not fall until at least `T_DF` cycles after the previous release.
- R8: When a request targets the device last read, or when `T_DF` cycles have already passed, the chip enable falls on the accepting edge. The response then comes `LAT` cycles after acceptance.
- R9: From acceptance until the response cycle, `req_ready_o` is low. No chip enable is low while `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | DEV_AW+SEL_W | Request address: device select above device address |
| rsp_valid_o | output | 1 | One-cycle strobe, read data valid |
| rsp_data_o | output | DATA_W | Captured byte |
| mem_addr_o | output | DEV_AW | Shared address bus to all devices |
| mem_ce_no | output | 2**SEL_W | Per-device chip enable, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_data_i | input | DATA_W | Shared data bus from the devices |

## Verification
A same-device read (or one whose turnaround has already elapsed) accepted on edge a should give its strobe on edge a+LAT. A read of a different device waits for the later of a and the previous release plus `T_DF`, and its strobe comes LAT cycles after that. The bench computes this edge for every request and compares it with the cycle in which it sees the strobe. The bench's memory model drives the correct byte only when the address, chip enable and output enable ages each meet their limit by the next edge; otherwise it drives the inverted byte. A capture that comes even one cycle early therefore returns a wrong byte. The output enable delay, the enable overlap, address stability and the turnaround gap are watched on every falling clock edge, measured against the cycle in which the chip enable fell or was released.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACCESS = 2'd2
  } rd_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
  parameter int unsigned SEL_W = 2
) (
  input  logic                    en_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [(1<<SEL_W)-1:0]   ce_n_o
);
  localparam int unsigned N_DEV = 1 << SEL_W;

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    assign ce_n_o[i] = !(en_i && (sel_i == SEL_W'(i)));
  end

endmodule

// File: rtl/eprom_access_timer.sv
module eprom_access_timer #(
  parameter int unsigned LAT    = 7,
  parameter int unsigned OE_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic oe_go_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (done_o) run_q <= 1'b0;
    end
  end

  assign done_o = run_q && (cnt_q == CW'(LAT - 1));

  if (OE_DLY == 0) begin : g_oe_now
    assign oe_go_o = start_i;
  end else begin : g_oe_late
    assign oe_go_o = run_q && (cnt_q == CW'(OE_DLY - 1));
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_OE_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !oe_go_o); // R4

endmodule

// File: rtl/eprom_bus_turnaround.sv
module eprom_bus_turnaround #(
  parameter int unsigned T_DF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic release_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(T_DF + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (release_i)       cnt_q <= CW'(T_DF);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // start allowed on the edge T_DF cycles after release
  assign busy_o = cnt_q > CW'(1);

  AST_BUSY_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (busy_o == (T_DF > 1))); // R7

endmodule

// File: rtl/eprom_bank_rd_ctrl.sv
module eprom_bank_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int unsigned DEV_AW = 19,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_ACC  = 7,
  parameter int unsigned T_CE   = 7,
  parameter int unsigned T_OE   = 4,
  parameter int unsigned T_DF   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [DEV_AW+SEL_W-1:0]   req_addr_i,
  output logic                      rsp_valid_o,
  output logic [DATA_W-1:0]         rsp_data_o,
  output logic [DEV_AW-1:0]         mem_addr_o,
  output logic [(1<<SEL_W)-1:0]     mem_ce_no,
  output logic                      mem_oe_no,
  input  logic [DATA_W-1:0]         mem_data_i
);
  localparam int unsigned N_DEV  = 1 << SEL_W;
  localparam int unsigned LAT    = max3(T_ACC, T_CE, T_OE);
  localparam int unsigned OE_DLY = LAT - T_OE;

  rd_state_e          state_q, state_d;
  logic [SEL_W-1:0]   sel_q, last_sel_q, req_sel, dec_sel;
  logic [DEV_AW-1:0]  addr_q;
  logic [N_DEV-1:0]   ce_n_q, dec_ce_n;
  logic               oe_n_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;
  logic               accept, start, capture, oe_go, busy;

  assign req_sel = req_addr_i[DEV_AW +: SEL_W];
  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign start   = (accept && !((req_sel != last_sel_q) && busy))
                || ((state_q == ST_WAIT) && !busy);
  assign dec_sel = (state_q == ST_IDLE) ? req_sel : sel_q;

  eprom_ce_decode #(.SEL_W(SEL_W)) i_dec (
    .en_i   (start),
    .sel_i  (dec_sel),
    .ce_n_o (dec_ce_n)
  );

  eprom_access_timer #(.LAT(LAT), .OE_DLY(OE_DLY)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .oe_go_o (oe_go),
    .done_o  (capture)
  );

  eprom_bus_turnaround #(.T_DF(T_DF)) i_turn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .release_i (capture),
    .busy_o    (busy)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = start ? ST_ACCESS : ST_WAIT;
      ST_WAIT:   if (!busy)  state_d = ST_ACCESS;
      ST_ACCESS: if (capture) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sel_q       <= '0;
      last_sel_q  <= '0;
      addr_q      <= '0;
      ce_n_q      <= '1;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= capture;
      if (accept) begin
        addr_q <= req_addr_i[DEV_AW-1:0];
        sel_q  <= req_sel;
      end
      if (start) begin
        ce_n_q <= dec_ce_n;
      end else if (capture) begin
        ce_n_q <= '1;
      end
      if (oe_go)        oe_n_q <= 1'b0;
      else if (capture) oe_n_q <= 1'b1;
      if (capture) begin
        rsp_data_q <= mem_data_i;
        last_sel_q <= sel_q;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = ce_n_q;
  assign mem_oe_no   = oe_n_q;

  AST_ONE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_ce_no) <= 1); // R2
  AST_OE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (mem_ce_no != '1)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ce_no != '1) |=> $stable(mem_addr_o)); // R3
  AST_RSP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ((mem_ce_no == '1) && mem_oe_no && req_ready_o)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R5
  AST_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R9

endmodule

// File: tb/test_eprom_bank_rd_ctrl.sv
module test_eprom_bank_rd_ctrl;
  localparam int unsigned DEV_AW = 19;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned T_ACC  = 7;
  localparam int unsigned T_CE   = 7;
  localparam int unsigned T_OE   = 4;
  localparam int unsigned T_DF   = 3;
  localparam int unsigned N_DEV  = 1 << SEL_W;
  localparam int          LAT    = 7;
  localparam int          OE_DLY = 3;
  localparam time         CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [DEV_AW+SEL_W-1:0] req_addr = '0;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [DEV_AW-1:0] mem_addr;
  logic [N_DEV-1:0] mem_ce_n;
  logic mem_oe_n;
  logic [DATA_W-1:0] mem_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  eprom_bank_rd_ctrl #(
    .DEV_AW(DEV_AW), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE), .T_DF(T_DF)
  ) i_eprom_bank_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_oe_no(mem_oe_n),
    .mem_data_i(mem_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int sel, input logic [DEV_AW-1:0] a);
    int v;
    v = int'(a) * 13 ^ (int'(a) >> 8) ^ (sel * 89) ^ 167;
    return DATA_W'(v);
  endfunction

  // memory model and bus monitors, on the falling edge
  logic [DEV_AW-1:0] p_addr = '0;
  logic [N_DEV-1:0]  p_ce = '1;
  logic              p_oe = 1'b1;
  int a_age = 0, c_age = 0, o_age = 0;
  int p_dev = 0, ce_fall_cyc = 0, rel_cyc = 0, rel_dev = 0;
  bit rel_seen = 1'b0;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r6 = 0, v_r7 = 0, v_r9 = 0;

  always @(negedge clk) begin
    int n_low, dev;
    n_low = $countones(~mem_ce_n);
    dev = 0;
    for (int i = 0; i < N_DEV; i++) if (!mem_ce_n[i]) dev = i;
    a_age = (mem_addr != p_addr) ? 0 : a_age + 1;
    c_age = (mem_ce_n != p_ce)   ? 0 : c_age + 1;
    o_age = (mem_oe_n != p_oe)   ? 0 : o_age + 1;
    if (n_low == 1 && !mem_oe_n && a_age + 1 >= T_ACC && c_age + 1 >= T_CE && o_age + 1 >= T_OE)
      mem_data = pat(dev, mem_addr);
    else
      mem_data = ~pat(dev, mem_addr);
    if (rst_ni) begin
      if (n_low > 1) v_r2++;
      if (!mem_oe_n && n_low != 1) v_r4++;
      if (n_low != 0 && req_ready) v_r9++;
      if (n_low != 0 && p_ce == mem_ce_n && mem_addr != p_addr) v_r3++;
      if (p_ce == '1 && mem_ce_n != '1) begin
        ce_fall_cyc = cyc;
        if (rel_seen && dev != rel_dev && cyc - rel_cyc < int'(T_DF)) v_r7++;
      end
      if (p_ce != '1 && mem_ce_n == '1) begin
        rel_cyc = cyc;
        rel_dev = p_dev;
        rel_seen = 1'b1;
        if (!mem_oe_n || !rsp_valid) v_r6++;
      end
      if (p_oe && !mem_oe_n && cyc - ce_fall_cyc != OE_DLY) v_r4++;
    end
    p_addr = mem_addr;
    p_ce = mem_ce_n;
    p_oe = mem_oe_n;
    p_dev = dev;
  end

  bit have_prev = 1'b0;
  int prev_rel = 0;
  int prev_sel = 0;

  task automatic do_read(input int sel, input logic [DEV_AW-1:0] a, input int gap);
    int acc, exp_start, exp_rsp;
    bit waits, same;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    req_addr = {SEL_W'(sel), a};
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", int'(req_ready), 0);
    same = !have_prev || sel == prev_sel;
    exp_start = acc;
    waits = 1'b0;
    if (!same && prev_rel + int'(T_DF) > acc) begin
      exp_start = prev_rel + int'(T_DF);
      waits = 1'b1;
    end
    exp_rsp = exp_start + LAT;
    while (!rsp_valid) @(negedge clk);
    if (waits)     chk(cyc == exp_rsp, "R7", cyc, exp_rsp);
    else           chk(cyc == exp_rsp, "R8", cyc, exp_rsp);
    chk(rsp_data == pat(sel, a), "R5", int'(rsp_data), int'(pat(sel, a)));
    chk(req_ready && mem_ce_n == '1 && mem_oe_n, "R6",
        int'({req_ready, mem_oe_n, mem_ce_n}), int'({1'b1, 1'b1, {N_DEV{1'b1}}}));
    prev_rel = cyc;
    prev_sel = sel;
    have_prev = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R5", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce_n == '1 && mem_oe_n && !rsp_valid, "R1",
        int'({req_ready, mem_oe_n, rsp_valid, mem_ce_n}),
        int'({1'b1, 1'b1, 1'b0, {N_DEV{1'b1}}}));
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_ce_n == '1 && mem_oe_n, "R1", int'(mem_ce_n), int'({N_DEV{1'b1}}));

    // directed corners
    do_read(0, '0, 0);
    do_read(0, '1, 0);              // same device back to back, R8
    do_read(3, 19'h00005, 0);       // device change, full turnaround, R7
    do_read(1, 19'h2AAAA, 1);       // device change, partial turnaround
    do_read(2, 19'h55555, 5);       // device change after turnaround elapsed
    do_read(2, 19'h7FFFF, 0);
    for (int d = 0; d < int'(N_DEV); d++) do_read(d, DEV_AW'(d * 4097 + 3), 0); // R2

    for (int n = 0; n < 80; n++) begin
      int sel, gap;
      sel = ($urandom % 2 == 0) ? prev_sel : int'($urandom % N_DEV);
      gap = int'($urandom % 5);
      do_read(sel, DEV_AW'($urandom), gap);
    end

    repeat (4) @(negedge clk);
    chk(v_r2 == 0, "R2", v_r2, 0);
    chk(v_r3 == 0, "R3", v_r3, 0);
    chk(v_r4 == 0, "R4", v_r4, 0);
    chk(v_r6 == 0, "R6", v_r6, 0);
    chk(v_r7 == 0, "R7", v_r7, 0);
    chk(v_r9 == 0, "R9", v_r9, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule